// File: doc/BRIEF.md
# Console Transmitter Register Interface

This block is the processor-facing half of a console transmitter. Software sees two registers selected by address bit 1: a status register and an output buffer. Writing a byte into the buffer starts a send. After a fixed number of clock cycles the block offers that byte to a downstream character sink on a valid/ready pair. Completion is reported through a done flag that software can poll, and through an interrupt request that software can enable.

The offer lasts one cycle. If the sink does not take the byte in that cycle, the block withdraws the offer, waits the same number of cycles again, and repeats. This continues until the sink takes the byte, and no error is ever flagged. Each accepted byte advances a free-running output counter. The bus is one byte lane wide. Address bit 0 marks an access to the odd (high) byte of a register.

The wait length is the parameter `WAIT_CYCLES`, which must be at least 1. Serialization, baud timing and character conversion belong to the sink.

Top module: `con_tx_regif`

## Requirements
- R1: With `rdEn` high, `regAddr[1]`=1 returns the last byte loaded into the buffer. `regAddr[1]`=0 returns the status byte: bit 7 is done, bit 6 is interrupt enable, and all other bits are 0. Reading has no side effect.
- R2: Only the interrupt-enable bit (bit 6) of the status register is writable. A status write never changes done. A write with `regAddr`=01 (odd status byte) changes nothing.
- R3: A status write (`regAddr`=00) with bit 6 = 0 clears interrupt enable and the interrupt request. A status write with bit 6 = 1 raises the request when done is set and interrupt enable was clear. When interrupt enable was already set, the request is left unchanged.
- R4: A buffer write with `regAddr`=10 loads `wrData` into the buffer. A buffer write with `regAddr`=11 leaves the buffer unchanged. Both kinds of buffer write clear done, clear the interrupt request and start a send.
- R5: `txValid` rises exactly `WAIT_CYCLES` clock edges after the edge that took the buffer write. It stays high for one cycle, with `txData` equal to the buffer.
- R6: If `txReady` is low during an offer, `txValid` drops on the next edge and rises again `WAIT_CYCLES` edges later. This repeats without limit, and done and `txCount` stay unchanged meanwhile.
- R7: An offer with `txReady` high sets done, increments `txCount` by one, and raises the interrupt request if interrupt enable is set. The interrupt request is never high while done or interrupt enable is clear.
- R8: A buffer write during a pending send restarts the countdown from the full wait, and only the newer byte is offered.
- R9: Reset clears the buffer, interrupt enable, the interrupt request and `txCount`, sets done, and cancels any pending send.
- R10: `txValid` is never high while done is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| rdEn | input | 1 | Register read enable; rdData is zero when low |
| regAddr | input | 2 | Bit 1: 0 status, 1 buffer; bit 0: odd byte |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte (combinational) |
| irqReq | output | 1 | Interrupt request level |
| txValid | output | 1 | Byte offered to the sink |
| txData | output | 8 | Byte being offered |
| txReady | input | 1 | Sink takes the byte when high with txValid |
| txCount | output | COUNT_W | Number of bytes accepted since reset |

## Verification
Every cycle, the assertions check the following:
- Nothing is offered while done is set, and a refused offer is withdrawn on the next edge.
- The counter steps exactly on a handshake.
- A buffer write leaves done and the request clear.
- Clearing interrupt enable drops the request, and an odd status write leaves enable untouched.
- The request implies both done and enable.

Some behaviour needs counted windows and data values, so only the bench scenarios show it:
- The exact wait of `WAIT_CYCLES` edges, both for the first offer and for every retry.
- The byte seen by the sink across all 256 values.
- The restart of the countdown by a second write.
- The odd-address buffer write that resends the old byte.
- A reset in the middle of a send.

// File: rtl/con_tx_pkg.sv
package con_tx_pkg;

  // Transmit sequencer state
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_WAIT  = 2'd1,
    TX_OFFER = 2'd2
  } txStateT;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic loadBuf;    // capture the write byte into the buffer
    logic clrDone;    // a send has started
    logic setDone;    // the sink accepted the byte
    logic writeIe;    // status write updates interrupt enable
    logic ieVal;      // new interrupt-enable value
    logic raiseIrq;   // assert the interrupt request
    logic clrIrq;     // drop the interrupt request (wins over raise)
    logic bumpCount;  // advance the output counter
  } txStrobeT;

endpackage

// File: rtl/con_tx_ctrl.sv
module con_tx_ctrl
  import con_tx_pkg::*;
#(
  parameter int WAIT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] regAddr,
  input  logic       ieBit,
  input  logic       doneFlag,
  input  logic       ieFlag,
  input  logic       txReady,
  output logic       txValid,
  output txStrobeT   strobes
);

  localparam int LOAD_VAL = (WAIT_CYCLES < 1) ? 1 : WAIT_CYCLES;
  localparam int CNT_W    = $clog2(LOAD_VAL + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOAD_VAL);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  txStateT          stateQ;
  logic [CNT_W-1:0] waitCnt;

  logic statWr;
  logic bufWr;
  logic handshake;
  logic ieAfter;

  // Address decode: bit 1 picks buffer, bit 0 marks odd byte
  always_comb begin
    statWr    = wrEn && !regAddr[1] && !regAddr[0];
    bufWr     = wrEn && regAddr[1];
    txValid   = (stateQ == TX_OFFER);
    handshake = txValid && txReady;
    ieAfter   = statWr ? ieBit : ieFlag;
  end

  // Strobe generation
  always_comb begin
    strobes           = '0;
    strobes.loadBuf   = bufWr && !regAddr[0];
    strobes.clrDone   = bufWr;
    strobes.setDone   = handshake && !bufWr;
    strobes.writeIe   = statWr;
    strobes.ieVal     = ieBit;
    strobes.clrIrq    = bufWr || (statWr && !ieBit);
    strobes.raiseIrq  = (statWr && ieBit && doneFlag && !ieFlag) ||
                        (handshake && ieAfter);
    strobes.bumpCount = handshake;
  end

  // Send sequencer with wait countdown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= TX_IDLE;
      waitCnt <= '0;
    end else if (bufWr) begin
      stateQ  <= TX_WAIT;
      waitCnt <= CNT_LOAD;
    end else begin
      unique case (stateQ)
        TX_WAIT: begin
          if (waitCnt == CNT_ONE) begin
            stateQ <= TX_OFFER;
          end else begin
            waitCnt <= waitCnt - CNT_ONE;
          end
        end
        TX_OFFER: begin
          if (txReady) begin
            stateQ <= TX_IDLE;
          end else begin
            stateQ  <= TX_WAIT;
            waitCnt <= CNT_LOAD;
          end
        end
        default: begin
          stateQ <= TX_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/con_tx_datapath.sv
module con_tx_datapath
  import con_tx_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  txStrobeT           strobes,
  input  logic [7:0]         wrByte,
  input  logic               rdEn,
  input  logic               rdSelBuf,
  output logic [7:0]         rdData,
  output logic [7:0]         txData,
  output logic               irqReq,
  output logic               doneFlag,
  output logic               ieFlag,
  output logic [COUNT_W-1:0] txCount
);

  localparam logic [COUNT_W-1:0] COUNT_STEP = COUNT_W'(1);

  logic [7:0] bufQ;
  logic       doneQ;
  logic       ieQ;
  logic       irqQ;
  logic [COUNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ   <= '0;
      doneQ  <= 1'b1;
      ieQ    <= 1'b0;
      irqQ   <= 1'b0;
      countQ <= '0;
    end else begin
      if (strobes.loadBuf) bufQ <= wrByte;
      if (strobes.clrDone)      doneQ <= 1'b0;
      else if (strobes.setDone) doneQ <= 1'b1;
      if (strobes.writeIe) ieQ <= strobes.ieVal;
      if (strobes.clrIrq)        irqQ <= 1'b0;
      else if (strobes.raiseIrq) irqQ <= 1'b1;
      if (strobes.bumpCount) countQ <= countQ + COUNT_STEP;
    end
  end

  // Read mux: buffer or status byte (done bit 7, enable bit 6)
  always_comb begin
    if (!rdEn)         rdData = '0;
    else if (rdSelBuf) rdData = bufQ;
    else               rdData = {doneQ, ieQ, 6'b0};
  end

  assign txData   = bufQ;
  assign irqReq   = irqQ;
  assign doneFlag = doneQ;
  assign ieFlag   = ieQ;
  assign txCount  = countQ;

endmodule

// File: rtl/con_tx_regif.sv
module con_tx_regif
  import con_tx_pkg::*;
#(
  parameter int WAIT_CYCLES = 4,
  parameter int COUNT_W     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [1:0]         regAddr,
  input  logic [7:0]         wrData,
  output logic [7:0]         rdData,
  output logic               irqReq,
  output logic               txValid,
  output logic [7:0]         txData,
  input  logic               txReady,
  output logic [COUNT_W-1:0] txCount
);

  txStrobeT strobes;
  logic     doneFlag;
  logic     ieFlag;

  con_tx_ctrl #(
    .WAIT_CYCLES(WAIT_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .regAddr  (regAddr),
    .ieBit    (wrData[6]),
    .doneFlag (doneFlag),
    .ieFlag   (ieFlag),
    .txReady  (txReady),
    .txValid  (txValid),
    .strobes  (strobes)
  );

  con_tx_datapath #(
    .COUNT_W(COUNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrByte   (wrData),
    .rdEn     (rdEn),
    .rdSelBuf (regAddr[1]),
    .rdData   (rdData),
    .txData   (txData),
    .irqReq   (irqReq),
    .doneFlag (doneFlag),
    .ieFlag   (ieFlag),
    .txCount  (txCount)
  );

endmodule

// File: rtl/con_tx_chk.sv
module con_tx_chk #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [1:0]         regAddr,
  input logic [7:0]         wrData,
  input logic               irqReq,
  input logic               txValid,
  input logic               txReady,
  input logic [COUNT_W-1:0] txCount,
  input logic               doneFlag,
  input logic               ieFlag
);

  // R10
  offer_not_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !doneFlag);

  // R6
  refused_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> !txValid);

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (txCount == $past(txCount) + COUNT_W'(1)));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txValid && txReady) |=> $stable(txCount));

  // R3
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 2'b00 && !wrData[6]) |=> (!irqReq && !ieFlag));

  // R4
  buf_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr[1]) |=> (!doneFlag && !irqReq && !txValid));

  // R2
  odd_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 2'b01) |=> (ieFlag == $past(ieFlag)));

  // R7
  irq_qualified_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (doneFlag && ieFlag));

endmodule

bind con_tx_regif con_tx_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .regAddr  (regAddr),
  .wrData   (wrData),
  .irqReq   (irqReq),
  .txValid  (txValid),
  .txReady  (txReady),
  .txCount  (txCount),
  .doneFlag (doneFlag),
  .ieFlag   (ieFlag)
);

// File: tb/sim_con_tx_regif.sv
`timescale 1ns/1ps
module sim_con_tx_regif;

  localparam int W   = 3;
  localparam int CW  = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrEn;
  logic          rdEn;
  logic [1:0]    regAddr;
  logic [7:0]    wrData;
  logic [7:0]    rdData;
  logic          irqReq;
  logic          txValid;
  logic [7:0]    txData;
  logic          txReady;
  logic [CW-1:0] txCount;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int expCount = 0;

  always #5 clk = ~clk;

  con_tx_regif #(.WAIT_CYCLES(W), .COUNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .irqReq(irqReq), .txValid(txValid),
    .txData(txData), .txReady(txReady), .txCount(txCount)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    rdEn = 1'b1; regAddr = a;
    #1;
    q = rdData;
    rdEn = 1'b0;
  endtask

  task automatic waitValid(output int n);
    n = 0;
    while (!txValid && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int n;
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; regAddr = '0; wrData = '0; txReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(2'b00, q); chk(q == 8'h80, "R9 status after reset", q, 8'h80);
    rd(2'b10, q); chk(q == 8'h00, "R9 buffer after reset", q, 0);
    chk(irqReq == 1'b0, "R9 irq after reset", irqReq, 0);
    chk(txValid == 1'b0, "R9 valid after reset", txValid, 0);
    chk(txCount == 0, "R9 count after reset", txCount, 0);

    // R5 R7 R1 sweep over all byte values, sink always ready, ie clear
    txReady = 1'b1;
    for (int b = 0; b < 256; b++) begin
      wr(2'b10, 8'(b));
      rd(2'b00, q); chk(q == 8'h00, "R4 done cleared by write", q, 0);
      waitValid(n);
      chk(n == W, "R5 offer delay", n, W);
      chk(txData == 8'(b), "R5 offered byte", txData, b);
      @(negedge clk);
      expCount++;
      chk(txValid == 1'b0, "R5 single-cycle offer", txValid, 0);
      chk(txCount == CW'(expCount), "R7 count step", txCount, expCount);
      rd(2'b00, q); chk(q == 8'h80, "R7 done set on accept", q, 8'h80);
      chk(irqReq == 1'b0, "R7 no irq without enable", irqReq, 0);
      rd(2'b10, q); chk(q == 8'(b), "R1 buffer readback", q, b);
    end

    // R6 refusals, k refused offers before acceptance
    for (int k = 0; k < 5; k++) begin
      txReady = 1'b0;
      wr(2'b10, 8'hA0 + 8'(k));
      waitValid(n); chk(n == W, "R6 first offer delay", n, W);
      for (int i = 0; i < k; i++) begin
        @(negedge clk);
        chk(txValid == 1'b0, "R6 offer withdrawn", txValid, 0);
        chk(txCount == CW'(expCount), "R6 count held", txCount, expCount);
        rd(2'b00, q); chk(q == 8'h00, "R6 done held clear", q, 0);
        waitValid(n); chk(n == W, "R6 retry delay", n, W);
        chk(txData == 8'hA0 + 8'(k), "R6 retry byte", txData, 8'hA0 + k);
      end
      txReady = 1'b1;
      @(negedge clk);
      expCount++;
      chk(txCount == CW'(expCount), "R7 count after retries", txCount, expCount);
      rd(2'b00, q); chk(q == 8'h80, "R7 done after retries", q, 8'h80);
    end

    // R3 R2 interrupt enable behaviour
    wr(2'b00, 8'h40);
    chk(irqReq == 1'b1, "R3 raise on enable with done", irqReq, 1);
    rd(2'b00, q); chk(q == 8'hC0, "R1 status with enable", q, 8'hC0);
    wr(2'b00, 8'h40);
    chk(irqReq == 1'b1, "R3 re-enable keeps request", irqReq, 1);
    wr(2'b00, 8'h00);
    chk(irqReq == 1'b0, "R3 clear on disable", irqReq, 0);
    wr(2'b00, 8'hBF);
    rd(2'b00, q); chk(q == 8'h80, "R2 done not writable", q, 8'h80);
    wr(2'b01, 8'h40);
    rd(2'b00, q); chk(q == 8'h80, "R2 odd status write ignored", q, 8'h80);
    chk(irqReq == 1'b0, "R2 odd status write no irq", irqReq, 0);
    wr(2'b00, 8'h40);
    chk(irqReq == 1'b1, "R3 raise again", irqReq, 1);
    wr(2'b10, 8'h55);
    chk(irqReq == 1'b0, "R4 write clears irq", irqReq, 0);
    rd(2'b00, q); chk(q == 8'h40, "R4 done clear enable kept", q, 8'h40);
    waitValid(n);
    @(negedge clk);
    expCount++;
    chk(irqReq == 1'b1, "R7 irq on accept with enable", irqReq, 1);
    rd(2'b00, q); chk(q == 8'hC0, "R7 status after accept", q, 8'hC0);

    // R4 odd buffer write keeps the buffer but still sends
    wr(2'b11, 8'h99);
    rd(2'b10, q); chk(q == 8'h55, "R4 odd buffer write keeps byte", q, 8'h55);
    rd(2'b00, q); chk(q == 8'h40, "R4 odd buffer write clears done", q, 8'h40);
    chk(irqReq == 1'b0, "R4 odd buffer write clears irq", irqReq, 0);
    waitValid(n); chk(n == W, "R4 odd write starts send", n, W);
    chk(txData == 8'h55, "R4 resend old byte", txData, 8'h55);
    @(negedge clk);
    expCount++;
    chk(txCount == CW'(expCount), "R4 odd write counted", txCount, expCount);

    // R8 restart of countdown
    wr(2'b10, 8'h11);
    @(negedge clk);
    @(negedge clk);
    chk(txValid == 1'b0, "R8 no offer yet", txValid, 0);
    wr(2'b10, 8'h22);
    waitValid(n); chk(n == W, "R8 restarted delay", n, W);
    chk(txData == 8'h22, "R8 newer byte offered", txData, 8'h22);
    @(negedge clk);
    expCount++;
    chk(txCount == CW'(expCount), "R8 one byte sent", txCount, expCount);

    // R9 reset during a pending send
    wr(2'b10, 8'h77);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    begin
      int seen = 0;
      for (int c = 0; c < W + 4; c++) begin
        @(negedge clk);
        if (txValid) seen++;
      end
      chk(seen == 0, "R9 send cancelled", seen, 0);
    end
    rd(2'b00, q); chk(q == 8'h80, "R9 status after mid-send reset", q, 8'h80);
    rd(2'b10, q); chk(q == 8'h00, "R9 buffer cleared", q, 0);
    chk(txCount == 0, "R9 count cleared", txCount, 0);
    chk(irqReq == 1'b0, "R9 irq cleared", irqReq, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule